// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A one-cycle strobe from an external prescaler advances it by one second, and a run input freezes or releases the count. The carries ripple through all seven fields in the same clock edge, so a single tick can take the whole state from the last second of a century to the first.

The hours byte carries its own format. Bit 7 chooses the 12-hour view, and bit 5 then marks the afternoon. The flag flips by itself when the clock passes noon and midnight. The host loads any field through a byte-wide write port and reads any field through a combinational read port. Offsets 0 to 6 address seconds, minutes, hours, weekday, date, month and year, in that order. Out-of-range BCD values loaded by the host are stored as given.

Top module: `rtc_calendar`

## Requirements
- R1: After synchronous reset the fields read seconds 00, minutes 00, hours 00 (24-hour midnight), weekday 01, date 01, month 01, year 00.
- R2: On an accepted tick the seconds advance in BCD from 00 to 59 and wrap to 00. The wrap carries into the minutes, which count the same way. A minute wrap carries into the hours.
- R3: With hours bit 7 at 0 (24-hour), the hours count 00 to 23 in BCD. The step from 23 to 00 carries one day into the calendar.
- R4: With hours bit 7 at 1 (12-hour), bit 5 is PM and bits 4:0 hold BCD 01 to 12. The step from 11 to 12 flips the PM bit. The step from 12 to 01 keeps it. The day carry happens only on the step from 11 PM to 12 AM.
- R5: Each day carry advances the weekday from 1 to 7 (Sunday is 1) and wraps it from 7 back to 1.
- R6: On a day carry the date returns to 01 after the last day of its month. Months 04, 06, 09 and 11 have 30 days and February has 28. February has 29 when the year value is divisible by 4. All other months have 31.
- R7: A date wrap advances the month from 01 to 12, and from 12 back to 01 with a carry into the year. The year wraps from 99 to 00.
- R8: A tick is accepted only while run is high. Otherwise no field changes.
- R9: A write with offset 0 to 6 loads that field with the data byte at the next edge. A write cycle discards any tick in the same cycle for every field. A write to offset 7 changes nothing.
- R10: rd_data shows, in the same cycle, the field at rd_addr. Offset 7 reads 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count enable; low freezes the time |
| tick | input | 1 | One-second strobe, one cycle wide |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Field offset for a write |
| wr_data | input | 8 | Byte to load |
| rd_addr | input | 3 | Field offset for a read |
| rd_data | output | 8 | Selected field, combinational |

## Verification
Random runs mix legal loads of every field, including both hour formats, with ticks, run toggles and write-tick collisions. Loads of 59 seconds and minutes are frequent, so the hour and calendar carries happen often. Directed cases cover the year-end cascade, the leap and non-leap end of February, and a 30-day month end. They also cover the 12-hour steps across 11 and 12 in both halves of the day, which separate the flag flip from the day carry. The cases for a frozen count, an offset-7 write and a write during a tick show that ignored stimulus leaves every field unchanged.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int REG_W    = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_REGS = 7;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC   = 3'd0,
        A_MIN   = 3'd1,
        A_HOUR  = 3'd2,
        A_WDAY  = 3'd3,
        A_DATE  = 3'd4,
        A_MONTH = 3'd5,
        A_YEAR  = 3'd6
    } reg_idx_e;

    typedef struct packed {
        logic [REG_W-1:0] sec;
        logic [REG_W-1:0] min;
        logic [REG_W-1:0] hour;
    } time_s;

    typedef struct packed {
        logic [REG_W-1:0] wday;
        logic [REG_W-1:0] date;
        logic [REG_W-1:0] month;
        logic [REG_W-1:0] year;
    } date_s;

    typedef struct packed {
        logic [REG_W-1:0] value;
        logic             carry;
    } hour_step_s;

    // Two-digit BCD increment without range check
    function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
        if (v[3:0] == 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // Year divisible by 4, computed on the BCD digits
    function automatic logic is_leap(input logic [REG_W-1:0] yr);
        if (yr[4] == 1'b0)
            return (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
        return (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
    endfunction

    function automatic logic [REG_W-1:0] last_day(input logic [REG_W-1:0] mo,
                                                  input logic [REG_W-1:0] yr);
        case (mo)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Next hour value for either format plus the carry into the calendar
    function automatic hour_step_s hour_next(input logic [REG_W-1:0] h);
        hour_step_s r;
        logic [REG_W-1:0] dig;
        logic pm;
        r.carry = 1'b0;
        if (h[7]) begin
            dig = h & 8'h1F;
            pm  = h[5];
            if (dig == 8'h12) begin
                dig = 8'h01;
            end else if (dig == 8'h11) begin
                dig     = 8'h12;
                r.carry = pm;
                pm      = ~pm;
            end else begin
                dig = bcd_inc(dig);
            end
            r.value = {1'b1, 1'b0, pm, dig[4:0]};
        end else begin
            if (h == 8'h23) begin
                r.value = 8'h00;
                r.carry = 1'b1;
            end else begin
                r.value = bcd_inc(h);
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output time_s             tm,
    output logic              day_step
);
    hour_step_s hs;
    logic       sec_wrap;
    logic       min_wrap;

    always_comb begin
        sec_wrap = (tm.sec == 8'h59);
        min_wrap = (tm.min == 8'h59);
        hs       = hour_next(tm.hour);
        day_step = adv && sec_wrap && min_wrap && hs.carry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm <= '{sec: 8'h00, min: 8'h00, hour: 8'h00};
        end else if (wr_en) begin
            case (reg_idx_e'(wr_sel))
                A_SEC:   tm.sec  <= wr_data;
                A_MIN:   tm.min  <= wr_data;
                A_HOUR:  tm.hour <= wr_data;
                default: ;
            endcase
        end else if (adv) begin
            tm.sec <= sec_wrap ? 8'h00 : bcd_inc(tm.sec);
            if (sec_wrap) begin
                tm.min <= min_wrap ? 8'h00 : bcd_inc(tm.min);
                if (min_wrap)
                    tm.hour <= hs.value;
            end
        end
    end

    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && tm.sec == 8'h59) |=> (tm.sec == 8'h00 && tm.min != $past(tm.min)));

    // R4
    noon_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && tm.sec == 8'h59 && tm.min == 8'h59 && tm.hour == 8'h91) |=> (tm.hour == 8'hB2));

    // R4
    twelve_to_one_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && tm.sec == 8'h59 && tm.min == 8'h59 && tm.hour[7] && tm.hour[4:0] == 5'h12)
        |=> (tm.hour == {1'b1, 1'b0, $past(tm.hour[5]), 5'h01}));

    // R3
    midnight_24_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && tm.sec == 8'h59 && tm.min == 8'h59 && tm.hour == 8'h23) |-> day_step);
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              day_step,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output date_s             dt
);
    logic [REG_W-1:0] month_end;
    logic             date_wrap;
    logic             month_wrap;

    always_comb begin
        month_end  = last_day(dt.month, dt.year);
        date_wrap  = (dt.date == month_end);
        month_wrap = (dt.month == 8'h12);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dt <= '{wday: 8'h01, date: 8'h01, month: 8'h01, year: 8'h00};
        end else if (wr_en) begin
            case (reg_idx_e'(wr_sel))
                A_WDAY:  dt.wday  <= wr_data;
                A_DATE:  dt.date  <= wr_data;
                A_MONTH: dt.month <= wr_data;
                A_YEAR:  dt.year  <= wr_data;
                default: ;
            endcase
        end else if (day_step) begin
            dt.wday <= (dt.wday == 8'h07) ? 8'h01 : bcd_inc(dt.wday);
            dt.date <= date_wrap ? 8'h01 : bcd_inc(dt.date);
            if (date_wrap) begin
                dt.month <= month_wrap ? 8'h01 : bcd_inc(dt.month);
                if (month_wrap)
                    dt.year <= (dt.year == 8'h99) ? 8'h00 : bcd_inc(dt.year);
            end
        end
    end

    // R5
    wday_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (day_step && dt.wday == 8'h07) |=> (dt.wday == 8'h01));

    // R7
    year_end_chk: assert property (@(posedge clk) disable iff (rst)
        (day_step && dt.date == 8'h31 && dt.month == 8'h12)
        |=> (dt.month == 8'h01 && dt.date == 8'h01 && dt.year != $past(dt.year)));

    // R6
    feb_leap_chk: assert property (@(posedge clk) disable iff (rst)
        (day_step && dt.month == 8'h02 && dt.date == 8'h28 && dt.year == 8'h24)
        |=> (dt.date == 8'h29 && dt.month == 8'h02));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data
);
    time_s tm;
    date_s dt;
    logic  adv;
    logic  day_step;

    assign adv = tick && run && !wr_en;

    rtc_time_chain u_time (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .wr_en    (wr_en),
        .wr_sel   (wr_addr),
        .wr_data  (wr_data),
        .tm       (tm),
        .day_step (day_step)
    );

    rtc_date_chain u_date (
        .clk      (clk),
        .rst      (rst),
        .day_step (day_step),
        .wr_en    (wr_en),
        .wr_sel   (wr_addr),
        .wr_data  (wr_data),
        .dt       (dt)
    );

    always_comb begin
        case (reg_idx_e'(rd_addr))
            A_SEC:   rd_data = tm.sec;
            A_MIN:   rd_data = tm.min;
            A_HOUR:  rd_data = tm.hour;
            A_WDAY:  rd_data = dt.wday;
            A_DATE:  rd_data = dt.date;
            A_MONTH: rd_data = dt.month;
            A_YEAR:  rd_data = dt.year;
            default: rd_data = '0;
        endcase
    end

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!(tick && run) && !wr_en) |=> ($stable(tm) && $stable(dt)));

    // R9
    year_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_YEAR) |=> (dt.year == $past(wr_data)));

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != A_SEC) |=> $stable(tm.sec));
endmodule

// File: tb/sim_rtc_calendar.sv
`timescale 1ns/100ps
module sim_rtc_calendar;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference model in decimal
    int ms = 0, mn = 0, mh = 0, mpm = 0, m12 = 0;
    int mwd = 1, mdt = 1, mmo = 1, myr = 0;

    always #2.5 clk = ~clk;

    rtc_calendar u0 (
        .clk(clk), .rst(rst), .run(run), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour_byte();
        if (m12 != 0) return 8'h80 | (mpm != 0 ? 8'h20 : 8'h00) | bcd(mh);
        return bcd(mh);
    endfunction

    function automatic logic [7:0] exp_reg(input int a);
        case (a)
            0: return bcd(ms);
            1: return bcd(mn);
            2: return hour_byte();
            3: return bcd(mwd);
            4: return bcd(mdt);
            5: return bcd(mmo);
            6: return bcd(myr);
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_tick();
        bit day;
        day = 0;
        ms++;
        if (ms == 60) begin
            ms = 0;
            mn++;
            if (mn == 60) begin
                mn = 0;
                if (m12 != 0) begin
                    if (mh == 11) begin
                        mh = 12;
                        if (mpm != 0) day = 1;
                        mpm = (mpm != 0) ? 0 : 1;
                    end else if (mh == 12) mh = 1;
                    else mh++;
                end else begin
                    if (mh == 23) begin mh = 0; day = 1; end
                    else mh++;
                end
            end
        end
        if (day) begin
            mwd = (mwd == 7) ? 1 : mwd + 1;
            if (mdt == dim(mmo, myr)) begin
                mdt = 1;
                if (mmo == 12) begin mmo = 1; myr = (myr + 1) % 100; end
                else mmo++;
            end else mdt++;
        end
    endtask

    // One clock: inputs set at negedge, released just after the edge
    task automatic cyc(input bit tk, input bit we, input int a, input logic [7:0] d);
        @(negedge clk);
        tick = tk; wr_en = we; wr_addr = 3'(a); wr_data = d;
        @(posedge clk);
        #1;
        tick = 0; wr_en = 0;
        if (!we && tk && run) model_tick();
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.2;
            total++;
            if (rd_data !== exp_reg(a)) begin
                bad++;
                $display("FAIL %s offset %0d actual=%h expected=%h", tag, a, rd_data, exp_reg(a));
            end
        end
    endtask

    task automatic put(input int a, input int v, input bit tk);
        case (a)
            0: ms = v;
            1: mn = v;
            3: mwd = v;
            4: mdt = v;
            5: mmo = v;
            6: myr = v;
            default: ;
        endcase
        cyc(tk, 1'b1, a, bcd(v));
    endtask

    task automatic put_hour(input int mode12, input int h, input int pm, input bit tk);
        m12 = mode12; mh = h; mpm = (mode12 != 0) ? pm : 0;
        cyc(tk, 1'b1, 2, hour_byte());
    endtask

    task automatic set_all(input int wd, input int dt, input int mo, input int yr,
                           input int mode12, input int h, input int pm, input int mi, input int s);
        put(3, wd, 0); put(4, 1, 0); put(5, mo, 0); put(6, yr, 0); put(4, dt, 0);
        put_hour(mode12, h, pm, 0); put(1, mi, 0); put(0, s, 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset values, R10 offset 7 reads 00
        check_all("R1 reset");

        // R8 frozen count
        run = 0;
        repeat (5) cyc(1, 0, 0, 8'h00);
        check_all("R8 run low");
        run = 1;

        // R2 plain second and carry into minutes
        cyc(1, 0, 0, 8'h00);
        check_all("R2 step");
        set_all(3, 10, 6, 21, 0, 7, 0, 59, 59);
        cyc(1, 0, 0, 8'h00);
        check_all("R2 hour carry");

        // R7 year-end cascade
        set_all(7, 31, 12, 99, 0, 23, 0, 59, 59);
        cyc(1, 0, 0, 8'h00);
        check_all("R7 century wrap");

        // R6 leap / non-leap February, 30-day month
        set_all(2, 28, 2, 24, 0, 23, 0, 59, 59);
        cyc(1, 0, 0, 8'h00);
        check_all("R6 leap 28");
        set_all(2, 29, 2, 24, 0, 23, 0, 59, 59);
        cyc(1, 0, 0, 8'h00);
        check_all("R6 leap 29");
        set_all(2, 28, 2, 23, 0, 23, 0, 59, 59);
        cyc(1, 0, 0, 8'h00);
        check_all("R6 non-leap");
        set_all(5, 30, 4, 23, 0, 23, 0, 59, 59);
        cyc(1, 0, 0, 8'h00);
        check_all("R6 thirty");

        // R4 12-hour steps, R5 weekday wrap
        set_all(4, 5, 5, 30, 1, 11, 0, 59, 59);
        cyc(1, 0, 0, 8'h00);
        check_all("R4 noon");
        set_all(4, 5, 5, 30, 1, 12, 1, 59, 59);
        cyc(1, 0, 0, 8'h00);
        check_all("R4 one pm");
        set_all(7, 5, 5, 30, 1, 11, 1, 59, 59);
        cyc(1, 0, 0, 8'h00);
        check_all("R4 R5 midnight");
        set_all(4, 5, 5, 30, 1, 12, 0, 59, 59);
        cyc(1, 0, 0, 8'h00);
        check_all("R4 one am");
        set_all(6, 5, 5, 30, 0, 23, 0, 59, 59);
        cyc(1, 0, 0, 8'h00);
        check_all("R3 midnight");

        // R9 write collides with tick, offset 7 write ignored
        set_all(1, 9, 9, 9, 0, 9, 0, 59, 59);
        put(1, 30, 1);
        check_all("R9 write beats tick");
        cyc(1, 1, 7, 8'h55);
        check_all("R9 offset 7");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 10) begin
                int a;
                bit tk;
                a = int'($urandom % 7);
                tk = 1'($urandom % 2);
                case (a)
                    0: put(0, int'($urandom % 60), tk);
                    1: put(1, int'($urandom % 60), tk);
                    2: begin
                        if ($urandom % 2 == 0) put_hour(0, int'($urandom % 24), 0, tk);
                        else put_hour(1, int'($urandom % 12) + 1, int'($urandom % 2), tk);
                    end
                    3: put(3, int'($urandom % 7) + 1, tk);
                    4: put(4, int'($urandom % dim(mmo, myr)) + 1, tk);
                    5: if (mdt <= 28) put(5, int'($urandom % 12) + 1, tk);
                    default: if (!(mmo == 2 && mdt == 29)) put(6, int'($urandom % 100), tk);
                endcase
                check_all("R9 random write");
            end else if (r < 18) begin
                put(0, 59, 0); put(1, 59, 0);
                cyc(1, 0, 0, 8'h00);
                check_all("R3 R4 R6 random rollover");
            end else if (r < 21) begin
                @(negedge clk);
                run = ~run;
            end else begin
                cyc(1'($urandom % 4 != 0), 0, 0, 8'h00);
                check_all(run ? "R2 random tick" : "R8 random frozen");
            end
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule